// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the control and status registers of a multi-channel DMA engine. Software reaches it through a simple register bus: a 10-bit word address, a write strobe, 32-bit write data and a read data path that answers in the same cycle. The datapath, which is outside this block, reports its events through set vectors. One vector feeds the error status register. The other four feed the transmit and receive end-of-buffer and descriptor-error status registers.

The register file has a configuration register with a soft reset, an interrupt enable and four channel-active registers, which are a set and a reset register for each direction. It also has per-channel descriptor table pointers and a buffer size for each receive channel. The number of transmit channels and the number of receive channels are parameters, each between 1 and 32. Addresses that belong to a channel at or above the configured count read as zero and ignore writes.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, configuration (0x180) reads 0x0007C000. Every other register, including table pointers and buffer sizes, reads 0.
- R2: A write to 0x180 stores the write data ANDed with 0x00FFC087.
- R3: A write to 0x180 with bit 31 set first clears error status (0x181), interrupt enable (0x182), the channel-active registers (0x184, 0x185, 0x190, 0x191) and the four event status registers (0x186, 0x187, 0x192, 0x193). Table pointers and buffer sizes keep their values.
- R4: A write to 0x181, 0x186, 0x187, 0x192 or 0x193 clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A bit that is high on a set vector reads as 1 in the next cycle. This holds when a clear write or a soft reset hits the same bit in the same cycle. The set vectors map as follows: err_set to 0x181, tx_eob_set to 0x186, tx_derr_set to 0x187, rx_eob_set to 0x192, rx_derr_set to 0x193.
- R6: Interrupt enable keeps write bits 4:0. Transmit channel-active registers (0x184 set, 0x185 reset) keep bits 31:28. Receive channel-active registers (0x190 set, 0x191 reset) keep bits 31:30.
- R7: The transmit table pointer of channel i is at 0x1A0+i. The receive table pointer of channel i is at 0x1C0+i. Both store all 32 bits.
- R8: The buffer size of receive channel i is at 0x1E0+i and keeps only bits 7:0.
- R9: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses include 0x183 and channel addresses at or above the channel count.
- R10: Read data reflects the addressed register combinationally. A write becomes visible on the first read after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| err_set | input | 32 | Datapath set vector for error status |
| tx_eob_set | input | 32 | Set vector for transmit end-of-buffer status |
| tx_derr_set | input | 32 | Set vector for transmit descriptor-error status |
| rx_eob_set | input | 32 | Set vector for receive end-of-buffer status |
| rx_derr_set | input | 32 | Set vector for receive descriptor-error status |

## Verification
Two functions can act on the same status bit in one cycle. The first is a hardware set from the datapath. The second is either a software write-one-to-clear or the soft reset started by a configuration write. The bench provokes both cases: in one cycle it pulses a set vector while it writes ones to the same bits of that register, or while it writes configuration with bit 31 high. The readback must show the set bits at 1 and every other cleared bit at 0. The behavioural model in the bench applies the clear first and ORs in the set afterwards, and it compares the read data with the model on every clock.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int MAX_CHANS = 32;

  localparam logic [ADDR_W-1:0] A_CFG     = 10'h180;
  localparam logic [ADDR_W-1:0] A_ERR     = 10'h181;
  localparam logic [ADDR_W-1:0] A_IEN     = 10'h182;
  localparam logic [ADDR_W-1:0] A_TXSET   = 10'h184;
  localparam logic [ADDR_W-1:0] A_TXRST   = 10'h185;
  localparam logic [ADDR_W-1:0] A_TXEOB   = 10'h186;
  localparam logic [ADDR_W-1:0] A_TXDERR  = 10'h187;
  localparam logic [ADDR_W-1:0] A_RXSET   = 10'h190;
  localparam logic [ADDR_W-1:0] A_RXRST   = 10'h191;
  localparam logic [ADDR_W-1:0] A_RXEOB   = 10'h192;
  localparam logic [ADDR_W-1:0] A_RXDERR  = 10'h193;
  localparam int B_TXPTR = 'h1A0;
  localparam int B_RXPTR = 'h1C0;
  localparam int B_RXBSZ = 'h1E0;

  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h00FF_C087;
  localparam logic [DATA_W-1:0] CFG_RST   = 32'h0007_C000;
  localparam logic [DATA_W-1:0] IEN_MASK  = 32'h0000_001F;
  localparam logic [DATA_W-1:0] TXACT_MSK = 32'hF000_0000;
  localparam logic [DATA_W-1:0] RXACT_MSK = 32'hC000_0000;
  localparam logic [DATA_W-1:0] PTR_MASK  = 32'hFFFF_FFFF;
  localparam logic [DATA_W-1:0] BSZ_MASK  = 32'h0000_00FF;

  // status update: software clear applied first, hardware set on top
  function automatic logic [DATA_W-1:0] stat_next(
    input logic [DATA_W-1:0] cur,
    input logic              wipe,
    input logic [DATA_W-1:0] clr,
    input logic [DATA_W-1:0] set);
    logic [DATA_W-1:0] base;
    base = wipe ? '0 : cur;
    return (base & ~clr) | set;
  endfunction
endpackage

// File: rtl/dma_ctl_stat.sv
module dma_ctl_stat
  import dma_ctl_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= stat_next(q, wipe, clr_eff, set_bits);
  end
endmodule

// File: rtl/dma_ctl_mreg.sv
module dma_ctl_mreg
  import dma_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = '1,
  parameter logic [DATA_W-1:0] RSTV = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RSTV;
    else if (we)   q <= wd & MASK;
    else if (wipe) q <= RSTV;
  end
endmodule

// File: rtl/dma_ctl_bank.sv
module dma_ctl_bank
  import dma_ctl_pkg::*;
#(
  parameter int                N    = 4,
  parameter int                BASE = B_TXPTR,
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd,
  output logic              hit
);
  logic [N-1:0]      sel;
  logic [DATA_W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(BASE + i);
    assign sel[i] = (addr == MY_A);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            regs[i] <= '0;
      else if (we && sel[i]) regs[i] <= wd & MASK;
    end
  end

  assign hit = |sel;

  always_comb begin
    rd = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) rd = regs[i];
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int TX_CHANS = 4,
  parameter int RX_CHANS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] err_set,
  input  logic [DATA_W-1:0] tx_eob_set,
  input  logic [DATA_W-1:0] tx_derr_set,
  input  logic [DATA_W-1:0] rx_eob_set,
  input  logic [DATA_W-1:0] rx_derr_set
);
  if (TX_CHANS < 1 || TX_CHANS > MAX_CHANS) begin : g_bad_tx
    $error("TX_CHANS out of range");
  end
  if (RX_CHANS < 1 || RX_CHANS > MAX_CHANS) begin : g_bad_rx
    $error("RX_CHANS out of range");
  end

  // named events for the checker
  logic wr_cfg, soft_rst;
  logic [DATA_W-1:0] cfg_q, err_q, ien_q, txs_q, txr_q, rxs_q, rxr_q;
  logic [DATA_W-1:0] txeob_q, txderr_q, rxeob_q, rxderr_q;
  logic [DATA_W-1:0] txp_rd, rxp_rd, bsz_rd;
  logic txp_hit, rxp_hit, bsz_hit, fixed_hit, addr_hit;

  assign wr_cfg   = reg_wr && (reg_addr == A_CFG);
  assign soft_rst = wr_cfg && reg_wdata[31];

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return reg_wr && (reg_addr == a);
  endfunction

  dma_ctl_mreg #(.MASK(CFG_MASK),  .RSTV(CFG_RST)) u_cfg (
    .clk, .rst_n, .wipe(1'b0), .we(wr_cfg), .wd(reg_wdata), .q(cfg_q));
  dma_ctl_mreg #(.MASK(IEN_MASK),  .RSTV('0)) u_ien (
    .clk, .rst_n, .wipe(soft_rst), .we(wr_at(A_IEN)),   .wd(reg_wdata), .q(ien_q));
  dma_ctl_mreg #(.MASK(TXACT_MSK), .RSTV('0)) u_txs (
    .clk, .rst_n, .wipe(soft_rst), .we(wr_at(A_TXSET)), .wd(reg_wdata), .q(txs_q));
  dma_ctl_mreg #(.MASK(TXACT_MSK), .RSTV('0)) u_txr (
    .clk, .rst_n, .wipe(soft_rst), .we(wr_at(A_TXRST)), .wd(reg_wdata), .q(txr_q));
  dma_ctl_mreg #(.MASK(RXACT_MSK), .RSTV('0)) u_rxs (
    .clk, .rst_n, .wipe(soft_rst), .we(wr_at(A_RXSET)), .wd(reg_wdata), .q(rxs_q));
  dma_ctl_mreg #(.MASK(RXACT_MSK), .RSTV('0)) u_rxr (
    .clk, .rst_n, .wipe(soft_rst), .we(wr_at(A_RXRST)), .wd(reg_wdata), .q(rxr_q));

  dma_ctl_stat u_err (
    .clk, .rst_n, .wipe(soft_rst), .clr_en(wr_at(A_ERR)),
    .clr_bits(reg_wdata), .set_bits(err_set), .q(err_q));
  dma_ctl_stat u_txeob (
    .clk, .rst_n, .wipe(soft_rst), .clr_en(wr_at(A_TXEOB)),
    .clr_bits(reg_wdata), .set_bits(tx_eob_set), .q(txeob_q));
  dma_ctl_stat u_txderr (
    .clk, .rst_n, .wipe(soft_rst), .clr_en(wr_at(A_TXDERR)),
    .clr_bits(reg_wdata), .set_bits(tx_derr_set), .q(txderr_q));
  dma_ctl_stat u_rxeob (
    .clk, .rst_n, .wipe(soft_rst), .clr_en(wr_at(A_RXEOB)),
    .clr_bits(reg_wdata), .set_bits(rx_eob_set), .q(rxeob_q));
  dma_ctl_stat u_rxderr (
    .clk, .rst_n, .wipe(soft_rst), .clr_en(wr_at(A_RXDERR)),
    .clr_bits(reg_wdata), .set_bits(rx_derr_set), .q(rxderr_q));

  dma_ctl_bank #(.N(TX_CHANS), .BASE(B_TXPTR), .MASK(PTR_MASK)) u_txptr (
    .clk, .rst_n, .addr(reg_addr), .we(reg_wr), .wd(reg_wdata), .rd(txp_rd), .hit(txp_hit));
  dma_ctl_bank #(.N(RX_CHANS), .BASE(B_RXPTR), .MASK(PTR_MASK)) u_rxptr (
    .clk, .rst_n, .addr(reg_addr), .we(reg_wr), .wd(reg_wdata), .rd(rxp_rd), .hit(rxp_hit));
  dma_ctl_bank #(.N(RX_CHANS), .BASE(B_RXBSZ), .MASK(BSZ_MASK)) u_rxbsz (
    .clk, .rst_n, .addr(reg_addr), .we(reg_wr), .wd(reg_wdata), .rd(bsz_rd), .hit(bsz_hit));

  logic [DATA_W-1:0] fixed_rd;
  always_comb begin
    fixed_hit = 1'b1;
    unique case (reg_addr)
      A_CFG:    fixed_rd = cfg_q;
      A_ERR:    fixed_rd = err_q;
      A_IEN:    fixed_rd = ien_q;
      A_TXSET:  fixed_rd = txs_q;
      A_TXRST:  fixed_rd = txr_q;
      A_TXEOB:  fixed_rd = txeob_q;
      A_TXDERR: fixed_rd = txderr_q;
      A_RXSET:  fixed_rd = rxs_q;
      A_RXRST:  fixed_rd = rxr_q;
      A_RXEOB:  fixed_rd = rxeob_q;
      A_RXDERR: fixed_rd = rxderr_q;
      default: begin
        fixed_rd  = '0;
        fixed_hit = 1'b0;
      end
    endcase
  end

  assign addr_hit  = fixed_hit | txp_hit | rxp_hit | bsz_hit;
  assign reg_rdata = fixed_rd | txp_rd | rxp_rd | bsz_rd;
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
  import dma_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] err_set,
  input logic              wr_cfg,
  input logic              soft_rst,
  input logic              err_clr,
  input logic              addr_hit,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] err_q,
  input logic [DATA_W-1:0] ien_q,
  input logic [DATA_W-1:0] txs_q,
  input logic [DATA_W-1:0] rxs_q
);
  p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> cfg_q == ($past(reg_wdata) & CFG_MASK));

  p_soft_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ien_q == '0) && (txs_q == '0) && (rxs_q == '0)
                 && (err_q == $past(err_set)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !soft_rst) |=>
      err_q == (($past(err_q) & ~$past(reg_wdata)) | $past(err_set)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> (err_q & $past(err_set)) == $past(err_set));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> reg_rdata == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && err_set == '0) |=> $stable(err_q) && $stable(cfg_q));
endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
  .clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata, .err_set,
  .wr_cfg, .soft_rst,
  .err_clr(reg_wr && (reg_addr == dma_ctl_pkg::A_ERR)),
  .addr_hit, .cfg_q, .err_q, .ien_q, .txs_q, .rxs_q);

// File: tb/dma_ctl_regs_tb_top.sv
module dma_ctl_regs_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int TXN = 4;
  localparam int RXN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0, rdata;
  logic [31:0] es = '0, teob = '0, tde = '0, reob = '0, rde = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_ctl_regs #(.TX_CHANS(TXN), .RX_CHANS(RXN)) dut_i (
    .clk, .rst_n, .reg_addr(addr), .reg_wr(wr), .reg_wdata(wd), .reg_rdata(rdata),
    .err_set(es), .tx_eob_set(teob), .tx_derr_set(tde),
    .rx_eob_set(reob), .rx_derr_set(rde));

  // behavioural reference, keyed by address
  logic [31:0] mem [int];

  function automatic logic [31:0] m_rd(input int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic m_reset();
    mem.delete();
    mem['h180] = 32'h0007C000;
    foreach (ctrl_list[k]) if (ctrl_list[k] != 'h180) mem[ctrl_list[k]] = 0;
    for (int i = 0; i < TXN; i++) mem['h1A0 + i] = 0;
    for (int i = 0; i < RXN; i++) begin mem['h1C0 + i] = 0; mem['h1E0 + i] = 0; end
  endtask

  int ctrl_list [11] = '{'h180,'h181,'h182,'h184,'h185,'h186,'h187,'h190,'h191,'h192,'h193};

  task automatic m_tick(input int a, input bit w, input logic [31:0] d);
    int stat_a [5] = '{'h181,'h186,'h187,'h192,'h193};
    logic [31:0] setv [5];
    setv = '{es, teob, tde, reob, rde};
    if (w && a == 'h180 && d[31]) begin
      foreach (ctrl_list[k]) if (ctrl_list[k] != 'h180) mem[ctrl_list[k]] = 0;
    end
    for (int k = 0; k < 5; k++) begin
      logic [31:0] v = mem[stat_a[k]];
      if (w && a == stat_a[k]) v = v & ~d;
      mem[stat_a[k]] = v | setv[k];
    end
    if (w) begin
      if (a == 'h180) mem[a] = d & 32'h00FFC087;
      else if (a == 'h182) mem[a] = {27'd0, d[4:0]};
      else if (a == 'h184 || a == 'h185) mem[a] = {d[31:28], 28'd0};
      else if (a == 'h190 || a == 'h191) mem[a] = {d[31:30], 30'd0};
      else if (a >= 'h1A0 && a < 'h1A0 + TXN) mem[a] = d;
      else if (a >= 'h1C0 && a < 'h1C0 + RXN) mem[a] = d;
      else if (a >= 'h1E0 && a < 'h1E0 + RXN) mem[a] = {24'd0, d[7:0]};
    end
  endtask

  task automatic step(input int a, input bit w, input logic [31:0] d, input string tag,
                      input logic [31:0] s_err = 0, input logic [31:0] s_teob = 0,
                      input logic [31:0] s_tde = 0, input logic [31:0] s_reob = 0,
                      input logic [31:0] s_rde = 0);
    logic [31:0] exp;
    @(negedge clk);
    addr = 10'(a); wr = w; wd = d;
    es = s_err; teob = s_teob; tde = s_tde; reob = s_reob; rde = s_rde;
    #1;
    exp = m_rd(a);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
    @(posedge clk);
    m_tick(a, w, d);
  endtask

  task automatic rd(input int a, input string tag);
    step(a, 0, 0, tag);
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    foreach (ctrl_list[k]) rd(ctrl_list[k], "R1");
    rd('h1A3, "R1"); rd('h1C1, "R1"); rd('h1E1, "R1");
    // R2 configuration mask
    step('h180, 1, 32'h7FFF_FFFF, "R2"); rd('h180, "R2");
    step('h180, 1, 32'h0000_4005, "R2"); rd('h180, "R2");
    // R6 masks
    step('h182, 1, '1, "R6"); rd('h182, "R6");
    step('h184, 1, '1, "R6"); rd('h184, "R6");
    step('h185, 1, 32'hA5A5_A5A5, "R6"); rd('h185, "R6");
    step('h190, 1, '1, "R6"); rd('h190, "R6");
    step('h191, 1, 32'h4000_0001, "R6"); rd('h191, "R6");
    // R5 set inputs, R4 write-one-to-clear
    step('h183, 0, 0, "R5", 32'h0000_00F0, 32'h0000_000F, 32'h8000_0001, 32'h3, 32'hC0);
    rd('h181, "R5"); rd('h186, "R5"); rd('h187, "R5"); rd('h192, "R5"); rd('h193, "R5");
    step('h181, 1, 32'h0000_0030, "R4"); rd('h181, "R4");
    step('h186, 1, 32'h0000_0005, "R4"); rd('h186, "R4");
    step('h187, 1, '1, "R4"); rd('h187, "R4");
    step('h192, 1, 32'h1, "R4"); rd('h192, "R4");
    step('h193, 1, 32'h40, "R4"); rd('h193, "R4");
    // R5 set and clear on the same bit in one cycle
    step('h181, 1, 32'h0000_00C0, "R5", 32'h0000_0040); rd('h181, "R5");
    step('h186, 1, 32'h0000_000A, "R5", 0, 32'h0000_0008); rd('h186, "R5");
    // R7 pointers, R8 buffer sizes
    for (int i = 0; i < TXN; i++) step('h1A0 + i, 1, 32'hDEAD_0000 + i, "R7");
    for (int i = 0; i < TXN; i++) rd('h1A0 + i, "R7");
    for (int i = 0; i < RXN; i++) step('h1C0 + i, 1, 32'h1234_5670 + i, "R7");
    for (int i = 0; i < RXN; i++) rd('h1C0 + i, "R7");
    step('h1E0, 1, 32'hFFFF_ABCD, "R8"); step('h1E1, 1, 32'h0000_0177, "R8");
    rd('h1E0, "R8"); rd('h1E1, "R8");
    // R9 unmapped and out-of-range channels
    step('h183, 1, '1, "R9"); rd('h183, "R9");
    step('h1A0 + TXN, 1, '1, "R9"); rd('h1A0 + TXN, "R9");
    step('h1C0 + RXN, 1, '1, "R9"); rd('h1C0 + RXN, "R9");
    step('h1E0 + RXN, 1, '1, "R9"); rd('h1E0 + RXN, "R9");
    rd('h000, "R9"); rd('h3FF, "R9");
    for (int i = 0; i < TXN; i++) rd('h1A0 + i, "R9");
    // R3 soft reset, with a set landing in the same cycle (R5)
    step('h183, 0, 0, "R3", 32'hFF, 32'hFF, 32'hFF, 32'hFF, 32'hFF);
    step('h180, 1, 32'h8012_C083, "R3", 32'h0000_0100);
    foreach (ctrl_list[k]) rd(ctrl_list[k], "R3");
    rd('h1A1, "R3"); rd('h1C0, "R3"); rd('h1E0, "R3");
    // R10 back-to-back write then read
    step('h182, 1, 32'h0000_0003, "R10");
    step('h182, 1, 32'h0000_0011, "R10");
    rd('h182, "R10");
    @(negedge clk);
    wr = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule